// File: doc/BRIEF.md
# Accumulator Shift-Round-Saturate Store Converter

This block turns a 40-bit accumulator value into one 16-bit word for storing to memory. A signed shift count first scales the value: a positive count shifts left and a negative count shifts right. An optional rounding step then adds half of one output LSB. The block checks whether the scaled value still fits the 32-bit window whose upper half is stored, clamps it to a limit if saturation is enabled, and returns bits 31:16.

A mode input selects how the accumulator is read. In signed mode the value is two's complement. In unsigned mode all 40 bits are magnitude. The block only reads the accumulator and never writes it back. It does not update pointers or write to memory. Each accepted request gives its result one clock later, along with an overflow flag.

Top module: `srs_store_path`

## Requirements
- R1: A result appears on `vld_o` exactly one cycle after `vld_i` is high. `vld_o` is low in every cycle that follows a cycle with `vld_i` low.
- R2: A non-negative `shamt_i` shifts the extended accumulator left by that many bits, from 0 up to 31. In unsigned mode with rounding on, 0x00_0FAB_8678 shifted by 2 gives the word 0x3EAE.
- R3: A negative `shamt_i` (two's complement, down to -32) shifts right by its magnitude. The shift is arithmetic in signed mode (`uns_i`=0) and logical in unsigned mode (`uns_i`=1).
- R4: With `rnd_i`=1, 0x8000 is added to the shifted value before bits 31:16 are taken. With `rnd_i`=0 the low 16 bits are simply dropped.
- R5: `ovf_o` is 1 when the shifted and rounded value lies outside the 32-bit window. In signed mode the window is -2^31 to 2^31-1. In unsigned mode it is 0 to 2^32-1, and bit 39 counts as magnitude. The flag does not depend on `sat_i`.
- R6: In signed mode with `sat_i`=1, an out-of-window positive value stores 0x7FFF and an out-of-window negative value stores 0x8000.
- R7: In unsigned mode with `sat_i`=1, an out-of-window value stores 0xFFFF.
- R8: A value inside the window, or any value when `sat_i`=0, stores bits 31:16 of the shifted and rounded value (wrapped).
- R9: After reset, `word_o`, `ovf_o` and `vld_o` are 0. `word_o` and `ovf_o` keep their values through cycles with `vld_i` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_i | input | 40 | Accumulator value to convert |
| shamt_i | input | 6 | Signed shift count; negative values shift right |
| uns_i | input | 1 | 1 = unsigned interpretation, 0 = signed |
| rnd_i | input | 1 | Rounding enable |
| sat_i | input | 1 | Saturation enable |
| vld_i | input | 1 | Request strobe |
| word_o | output | 16 | Stored word |
| ovf_o | output | 1 | Window overflow flag |
| vld_o | output | 1 | Result strobe |

## Verification
The assertions assume that mode, shift, round and saturate inputs are stable and known in any cycle where `vld_i` is high. They judge the registered word against the overflow and rounded-high wires of the cycle before. The bench drives every input on the falling edge and holds it for a full cycle. It raises `vld_i` only together with fully defined operands. It keeps shift counts inside the 6-bit signed range, so the extremes +31 and -32 are reached but never exceeded.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic [1:0] {
    CLIP_NONE = 2'd0,
    CLIP_HIGH = 2'd1,
    CLIP_LOW  = 2'd2
  } srs_clip_e;
endpackage

// File: rtl/srs_shifter.sv
module srs_shifter #(
  parameter int ACC_W = 40,
  parameter int SH_W  = 6,
  parameter int WW    = 73
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic [SH_W-1:0]  shamt_i,
  input  logic             uns_i,
  output logic [WW-1:0]    shifted_o
);
  localparam int MAG_W = SH_W + 1;

  function automatic logic [WW-1:0] extend(input logic [ACC_W-1:0] a, input logic uns);
    logic fill;
    fill = uns ? 1'b0 : a[ACC_W-1];
    return {{(WW-ACC_W){fill}}, a};
  endfunction

  function automatic logic [WW-1:0] scale(input logic [WW-1:0] x,
                                          input logic [SH_W-1:0] cnt,
                                          input logic uns);
    logic [MAG_W-1:0] mag;
    mag = MAG_W'(0) - {cnt[SH_W-1], cnt};
    if (!cnt[SH_W-1]) return x << cnt;
    if (uns) return x >> mag;
    return WW'($signed(x) >>> mag);
  endfunction

  assign shifted_o = scale(extend(acc_i, uns_i), shamt_i, uns_i);
endmodule

// File: rtl/srs_round_clip.sv
module srs_round_clip
  import srs_pkg::*;
#(
  parameter int WW     = 73,
  parameter int FRAC_W = 16,
  parameter int OUT_W  = 16
) (
  input  logic [WW-1:0]    val_i,
  input  logic             uns_i,
  input  logic             rnd_i,
  input  logic             sat_i,
  output logic [OUT_W-1:0] hi_o,
  output logic             ovf_o,
  output srs_clip_e        clip_o,
  output logic [OUT_W-1:0] word_o
);
  localparam int TOP = FRAC_W + OUT_W;
  localparam logic [WW-1:0] HALF = WW'(1) << (FRAC_W - 1);
  localparam logic [OUT_W-1:0] U_MAX = {OUT_W{1'b1}};
  localparam logic [OUT_W-1:0] S_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] S_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  logic [WW-1:0] rounded;

  function automatic logic out_of_window(input logic [WW-1:0] v, input logic uns);
    if (uns) return |v[WW-1:TOP];
    return !((&v[WW-1:TOP-1]) || !(|v[WW-1:TOP-1]));
  endfunction

  assign rounded = rnd_i ? val_i + HALF : val_i;
  assign hi_o    = rounded[TOP-1:FRAC_W];
  assign ovf_o   = out_of_window(rounded, uns_i);

  always_comb begin
    clip_o = CLIP_NONE;
    if (sat_i && ovf_o) clip_o = (!uns_i && rounded[WW-1]) ? CLIP_LOW : CLIP_HIGH;
  end

  always_comb begin
    unique case (clip_o)
      CLIP_HIGH: word_o = uns_i ? U_MAX : S_MAX;
      CLIP_LOW:  word_o = S_MIN;
      default:   word_o = hi_o;
    endcase
  end
endmodule

// File: rtl/srs_store_path.sv
module srs_store_path
  import srs_pkg::*;
#(
  parameter int ACC_W  = 40,
  parameter int SH_W   = 6,
  parameter int FRAC_W = 16,
  parameter int OUT_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] acc_i,
  input  logic [SH_W-1:0]  shamt_i,
  input  logic             uns_i,
  input  logic             rnd_i,
  input  logic             sat_i,
  input  logic             vld_i,
  output logic [OUT_W-1:0] word_o,
  output logic             ovf_o,
  output logic             vld_o
);
  localparam int MAX_LSH = (1 << (SH_W - 1)) - 1;
  localparam int WW      = ACC_W + MAX_LSH + 2;

  logic [WW-1:0]    shifted_w;
  logic [OUT_W-1:0] hi_w;
  logic [OUT_W-1:0] next_word_w;
  logic             ovf_w;
  srs_clip_e        clip_w;

  srs_shifter #(.ACC_W(ACC_W), .SH_W(SH_W), .WW(WW)) u_shift (
    .acc_i(acc_i), .shamt_i(shamt_i), .uns_i(uns_i), .shifted_o(shifted_w)
  );

  srs_round_clip #(.WW(WW), .FRAC_W(FRAC_W), .OUT_W(OUT_W)) u_clip (
    .val_i(shifted_w), .uns_i(uns_i), .rnd_i(rnd_i), .sat_i(sat_i),
    .hi_o(hi_w), .ovf_o(ovf_w), .clip_o(clip_w), .word_o(next_word_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o <= '0;
      ovf_o  <= 1'b0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        word_o <= next_word_w;
        ovf_o  <= ovf_w;
      end
    end
  end

  assert_valid_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> vld_o);
  assert_valid_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> !vld_o);
  assert_signed_clip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && !uns_i && sat_i && ovf_w) |=>
      (ovf_o && (word_o == {1'b0, {(OUT_W-1){1'b1}}} || word_o == {1'b1, {(OUT_W-1){1'b0}}})));
  assert_unsigned_clip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && uns_i && sat_i && ovf_w) |=> (ovf_o && word_o == {OUT_W{1'b1}}));
  assert_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && !ovf_w) |=> (!ovf_o && word_o == $past(hi_w)));
  assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_i && !sat_i) |=> (word_o == $past(hi_w)));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |=> ($stable(word_o) && $stable(ovf_o)));
endmodule

// File: tb/tb_srs_store_path.sv
module tb_srs_store_path;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [39:0] acc_i = '0;
  logic [5:0]  shamt_i = '0;
  logic        uns_i = 1'b0, rnd_i = 1'b0, sat_i = 1'b0, vld_i = 1'b0;
  logic [15:0] word_o;
  logic        ovf_o, vld_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  srs_store_path dut (
    .clk(clk), .rst_n(rst_n), .acc_i(acc_i), .shamt_i(shamt_i), .uns_i(uns_i),
    .rnd_i(rnd_i), .sat_i(sat_i), .vld_i(vld_i),
    .word_o(word_o), .ovf_o(ovf_o), .vld_o(vld_o)
  );

  typedef struct packed {
    logic [39:0] acc;
    logic [5:0]  sh;
    logic        uns, rnd, sat;
    logic [15:0] w;
    logic        ovf;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{40'h00_0FAB_8678, 6'd2,    1'b1, 1'b1, 1'b1, 16'h3EAE, 1'b0, 4'd2}, // R2
    '{40'h00_0FAB_8678, 6'd2,    1'b0, 1'b1, 1'b1, 16'h3EAE, 1'b0, 4'd2}, // R2
    '{40'h00_1234_5678, 6'd0,    1'b0, 1'b0, 1'b1, 16'h1234, 1'b0, 4'd4}, // R4
    '{40'h00_1234_8000, 6'd0,    1'b0, 1'b1, 1'b1, 16'h1235, 1'b0, 4'd4}, // R4
    '{40'h00_1234_7FFF, 6'd0,    1'b0, 1'b1, 1'b1, 16'h1234, 1'b0, 4'd4}, // R4
    '{40'h00_4000_0000, 6'd1,    1'b0, 1'b0, 1'b1, 16'h7FFF, 1'b1, 4'd6}, // R6
    '{40'h00_4000_0000, 6'd1,    1'b0, 1'b0, 1'b0, 16'h8000, 1'b1, 4'd8}, // R8
    '{40'hFF_8000_0000, 6'd1,    1'b0, 1'b0, 1'b1, 16'h8000, 1'b1, 4'd6}, // R6
    '{40'hFF_8000_0000, 6'd1,    1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 4'd8}, // R8
    '{40'hFF_FFFF_8000, 6'd0,    1'b0, 1'b1, 1'b1, 16'h0000, 1'b0, 4'd4}, // R4
    '{40'h80_0000_0000, 6'd0,    1'b1, 1'b0, 1'b1, 16'hFFFF, 1'b1, 4'd7}, // R7
    '{40'h80_0000_0000, 6'd0,    1'b0, 1'b0, 1'b1, 16'h8000, 1'b1, 4'd5}, // R5
    '{40'hF0_0000_0000, 6'h34,   1'b0, 1'b0, 1'b1, 16'hFF00, 1'b0, 4'd3}, // R3
    '{40'hF0_0000_0000, 6'h34,   1'b1, 1'b0, 1'b1, 16'h0F00, 1'b0, 4'd3}, // R3
    '{40'h00_0000_0001, 6'd31,   1'b0, 1'b0, 1'b1, 16'h7FFF, 1'b1, 4'd2}, // R2
    '{40'h00_0000_0001, 6'd31,   1'b1, 1'b0, 1'b1, 16'h8000, 1'b0, 4'd2}, // R2
    '{40'h00_7FFF_8000, 6'd0,    1'b0, 1'b1, 1'b1, 16'h7FFF, 1'b1, 4'd5}, // R5
    '{40'h00_FFFF_8000, 6'd0,    1'b1, 1'b1, 1'b1, 16'hFFFF, 1'b1, 4'd7}, // R7
    '{40'h00_FFFF_8000, 6'd0,    1'b1, 1'b1, 1'b0, 16'h0000, 1'b1, 4'd8}, // R8
    '{40'h80_0000_0000, 6'h20,   1'b0, 1'b0, 1'b1, 16'hFFFF, 1'b0, 4'd3}, // R3
    '{40'h80_0000_0000, 6'h20,   1'b1, 1'b0, 1'b1, 16'h0000, 1'b0, 4'd3}  // R3
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset values
    check("R9 reset word", 32'(word_o), 32'h0);
    check("R9 reset ovf", 32'(ovf_o), 32'h0);
    check("R1 reset vld", 32'(vld_o), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      acc_i = VEC[i].acc; shamt_i = VEC[i].sh; uns_i = VEC[i].uns;
      rnd_i = VEC[i].rnd; sat_i = VEC[i].sat; vld_i = 1'b1;
      @(negedge clk);
      check($sformatf("R%0d vec%0d word", VEC[i].req, i), 32'(word_o), 32'(VEC[i].w));
      check($sformatf("R%0d vec%0d ovf", VEC[i].req, i), 32'(ovf_o), 32'(VEC[i].ovf));
      check($sformatf("R1 vec%0d vld", i), 32'(vld_o), 32'h1);
    end

    // R9: inputs change with no strobe, last result (vec 20: 0x0000, ovf 0) holds
    vld_i = 1'b0; acc_i = 40'h00_4000_0000; shamt_i = 6'd1; uns_i = 1'b0; sat_i = 1'b0;
    @(negedge clk);
    check("R1 idle vld", 32'(vld_o), 32'h0);
    check("R9 hold word", 32'(word_o), 32'h0);
    check("R9 hold ovf", 32'(ovf_o), 32'h0);
    @(negedge clk);
    check("R9 hold word 2", 32'(word_o), 32'h0);

    // R1: single-cycle strobe gives a single-cycle result
    vld_i = 1'b1; acc_i = 40'h00_0FAB_8678; shamt_i = 6'd2; uns_i = 1'b1; rnd_i = 1'b1; sat_i = 1'b1;
    @(negedge clk);
    vld_i = 1'b0;
    check("R1 one-cycle vld", 32'(vld_o), 32'h1);
    check("R2 one-cycle word", 32'(word_o), 32'h3EAE);
    @(negedge clk);
    check("R1 vld drops", 32'(vld_o), 32'h0);
    check("R9 word after drop", 32'(word_o), 32'h3EAE);

    // R3: right shift by 1, signed vs unsigned on a negative input
    vld_i = 1'b1; acc_i = 40'hFF_FFFE_0000; shamt_i = 6'h3F; uns_i = 1'b0; rnd_i = 1'b0;
    @(negedge clk);
    check("R3 arith -1", 32'(word_o), 32'hFFFF);
    check("R5 arith -1 ovf", 32'(ovf_o), 32'h0);
    uns_i = 1'b1;
    @(negedge clk);
    check("R3 logic -1", 32'(word_o), 32'hFFFF);
    check("R7 logic -1 ovf", 32'(ovf_o), 32'h1);
    vld_i = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule